// File: doc/BRIEF.md
# Host Mailbox with FIFO Status Register

This block sits between a byte-wide synchronous host bus and a controller core. The host sends command bytes by writing the data offset. They enter a host-to-controller FIFO, which the controller drains through a valid/ready port. Bytes that the controller produces enter a controller-to-host FIFO through a second valid/ready port, and the host pops them by reading the same data offset.

A packed control/status byte at a second offset reports three conditions:
- the outbound FIFO is full;
- the outbound FIFO is more than half full;
- the inbound FIFO is empty.

The same byte holds an interrupt enable bit and an interrupt pending bit. A controller event pulse sets the pending bit, and the host clears it by writing one to it. The interrupt output is high while the pending bit and the enable bit are both set.

A host that sees the half-full bit clear may write a burst of half the FIFO depth without polling the full bit. With the default depth of 512, that burst is 256 bytes, which covers a 255-byte burst with room to spare.

Top module: `host_mailbox`

## Requirements
- R1: A host write strobe at offset 0 queues the byte in the host-to-controller FIFO. The controller port presents the queued bytes in arrival order. `h2c_valid` is high exactly while that FIFO holds at least one byte, and a byte leaves the FIFO on each cycle with `h2c_valid` and `h2c_ready` both high.
- R2: Status bit 0 reads 1 exactly when the host-to-controller FIFO holds TX_DEPTH bytes. A data write made while it is full is discarded and changes neither the FIFO contents nor their order.
- R3: Status bit 1 reads 1 exactly when the host-to-controller occupancy exceeds TX_DEPTH/2. While it reads 0, at least TX_DEPTH/2 further writes are accepted.
- R4: Status bit 2 reads 1 exactly when the controller-to-host FIFO is empty.
- R5: A host read strobe at offset 0 returns the oldest byte of the controller-to-host FIFO and removes it. When that FIFO is empty, the read returns 0x00 and removes nothing.
- R6: Status bit 6 is the interrupt enable. A host write at offset 4 loads it from bit 6 of the written byte, and a status read returns the current value.
- R7: Status bit 5 is the interrupt pending flag. A cycle with `irq_event` high sets it. A host write at offset 4 with bit 5 set clears it, and a write with bit 5 clear leaves it unchanged. When an event and a clear fall in the same cycle, the event wins.
- R8: `irq` is high exactly when both the pending bit and the enable bit are 1.
- R9: Host writes cannot change status bits 0 through 3 or bit 7. Bits 3, 4 and 7 always read 0.
- R10: After reset, both FIFOs are empty, the enable and pending bits are 0, the status byte reads 0x04, `irq` is 0, `h2c_valid` is 0 and `c2h_ready` is 1.
- R11: Host reads at any offset other than 0 and 4 return 0x00. Host writes at those offsets change no state.
- R12: `c2h_ready` is high exactly when the controller-to-host FIFO is not full. A byte is accepted on each cycle with `c2h_valid` and `c2h_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid during the strobe cycle |
| h2c_valid | output | 1 | Host-to-controller byte available |
| h2c_ready | input | 1 | Controller takes the byte |
| h2c_data | output | 8 | Host-to-controller byte |
| c2h_valid | input | 1 | Controller offers a byte |
| c2h_ready | output | 1 | Controller-to-host FIFO can accept |
| c2h_data | input | 8 | Controller-to-host byte |
| irq_event | input | 1 | Sets the interrupt pending bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with TX_DEPTH=16 and RX_DEPTH=4. With these small depths, the full, half-full and empty edges come round many times within a short random run. The half-full step moves from 8 to 9 bytes, so the one-below and one-above cases of the threshold are easy to hit directly. A full inbound FIFO is reached after four controller pushes, which exercises back-pressure on `c2h_ready` and repeated empty reads often.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int STAT_FULL  = 0;
  localparam int STAT_HALF  = 1;
  localparam int STAT_RXEMP = 2;
  localparam int STAT_PEND  = 5;
  localparam int STAT_EN    = 6;

  // occupancy at which the half-full flag rises
  function automatic int half_mark(input int depth);
    return depth / 2 + 1;
  endfunction

  function automatic logic [7:0] pack_status(input logic full, input logic half,
                                             input logic rx_empty, input logic pend,
                                             input logic en);
    logic [7:0] s;
    s = 8'h00;
    s[STAT_FULL]  = full;
    s[STAT_HALF]  = half;
    s[STAT_RXEMP] = rx_empty;
    s[STAT_PEND]  = pend;
    s[STAT_EN]    = en;
    return s;
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_req,
  input  logic [WIDTH-1:0]             push_data,
  input  logic                         pop_req,
  output logic [WIDTH-1:0]             head,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         push_ok,
  output logic                         pop_ok
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CAP);
  assign empty   = (cnt == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign head    = mem[rd_ptr];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CAP);
  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_req) |=> full);
  // R1
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic ctl_wr,
  input  logic wr_en_bit,
  input  logic wr_clr_bit,
  output logic en,
  output logic pend,
  output logic irq
);
  logic clr_hit;
  assign clr_hit = ctl_wr && wr_clr_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (ctl_wr) en <= wr_en_bit;
      if (evt)          pend <= 1'b1;
      else if (clr_hit) pend <= 1'b0;
    end
  end

  assign irq = pend && en;

  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend);
  // R7
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !evt) |=> !pend);
  // R6
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (en == $past(wr_en_bit)));
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import mbx_pkg::*;
#(
  parameter int TX_DEPTH = 512,
  parameter int RX_DEPTH = 16,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              h2c_valid,
  input  logic              h2c_ready,
  output logic [7:0]        h2c_data,
  input  logic              c2h_valid,
  output logic              c2h_ready,
  input  logic [7:0]        c2h_data,
  input  logic              irq_event,
  output logic              irq
);
  localparam int TCW = $clog2(TX_DEPTH+1);
  localparam int RCW = $clog2(RX_DEPTH+1);
  localparam logic [TCW-1:0]    HALF_AT  = TCW'(half_mark(TX_DEPTH));
  localparam logic [TCW-1:0]    TX_CAP   = TCW'(TX_DEPTH);
  localparam logic [RCW-1:0]    RX_CAP   = RCW'(RX_DEPTH);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CTL_OFS  = ADDR_W'(4);

  // decoded host events
  logic data_wr, data_rd, ctl_wr;
  assign data_wr = host_cs && host_we  && (host_addr == DATA_OFS);
  assign data_rd = host_cs && !host_we && (host_addr == DATA_OFS);
  assign ctl_wr  = host_cs && host_we  && (host_addr == CTL_OFS);

  logic [7:0]     tx_head, rx_head;
  logic           tx_full, tx_empty, rx_full, rx_empty;
  logic [TCW-1:0] tx_level;
  logic [RCW-1:0] rx_level;
  logic           tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic           tx_half, irq_en, irq_pend;
  logic [7:0]     status;

  mbx_fifo #(.DEPTH(TX_DEPTH), .WIDTH(8)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push_req(data_wr), .push_data(host_wdata),
    .pop_req(h2c_ready), .head(tx_head),
    .full(tx_full), .empty(tx_empty), .level(tx_level),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  mbx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push_req(c2h_valid), .push_data(c2h_data),
    .pop_req(data_rd), .head(rx_head),
    .full(rx_full), .empty(rx_empty), .level(rx_level),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  mbx_irq irq_i (
    .clk(clk), .rst_n(rst_n), .evt(irq_event), .ctl_wr(ctl_wr),
    .wr_en_bit(host_wdata[STAT_EN]), .wr_clr_bit(host_wdata[STAT_PEND]),
    .en(irq_en), .pend(irq_pend), .irq(irq)
  );

  assign tx_half   = (tx_level >= HALF_AT);
  assign status    = pack_status(tx_full, tx_half, rx_empty, irq_pend, irq_en);
  assign h2c_valid = !tx_empty;
  assign h2c_data  = tx_head;
  assign c2h_ready = !rx_full;

  always_comb begin
    host_rdata = 8'h00;
    if (host_cs && !host_we) begin
      if (host_addr == DATA_OFS)     host_rdata = rx_empty ? 8'h00 : rx_head;
      else if (host_addr == CTL_OFS) host_rdata = status;
    end
  end

  // R3
  half_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[STAT_HALF] |-> ((TX_CAP - tx_level) >= TCW'(TX_DEPTH/2)));
  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && rx_empty) |-> (host_rdata == 8'h00 && !rx_pop_ok));
  // R12
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_ok && !rx_pop_ok) |=> (rx_level <= RX_CAP && !rx_empty));
  // R1
  tx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop_ok && !tx_push_ok && tx_level == TCW'(1)) |=> !h2c_valid);
  // R9
  ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] == 1'b0 && status[4:3] == 2'b00));
endmodule

// File: tb/host_mailbox_tb.sv
module host_mailbox_tb_top;
  localparam int TXD = 16;
  localparam int RXD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_cs = 0, host_we = 0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic h2c_valid, h2c_ready = 0;
  logic [7:0] h2c_data;
  logic c2h_valid = 0, c2h_ready;
  logic [7:0] c2h_data = '0;
  logic irq_event = 0, irq;

  always #2.5 clk = ~clk;

  host_mailbox #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .h2c_valid(h2c_valid), .h2c_ready(h2c_ready), .h2c_data(h2c_data),
    .c2h_valid(c2h_valid), .c2h_ready(c2h_ready), .c2h_data(c2h_data),
    .irq_event(irq_event), .irq(irq)
  );

  int total = 0, bad = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  bit en_m = 0, pend_m = 0;

  function automatic logic [7:0] exp_status(int txn, int rxn, bit en, bit pend);
    logic [7:0] v;
    v = {1'b0, en, pend, 2'b00, (rxn == 0), (2 * txn > TXD), (txn == TXD)};
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    host_cs = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_cs = 0; host_we = 0;
    if (a == 4'd0 && tx_q.size() < TXD) tx_q.push_back(d);
    if (a == 4'd4) begin
      en_m = d[6];
      if (d[5]) pend_m = 0;
    end
  endtask

  task automatic host_rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_cs = 1; host_we = 0; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_cs = 0;
  endtask

  task automatic status_chk(string req);
    logic [7:0] s;
    host_rd(4'd4, s);
    chk(req, s, exp_status(tx_q.size(), rx_q.size(), en_m, pend_m));
    chk("R8 irq", {7'd0, irq}, {7'd0, en_m & pend_m});
  endtask

  task automatic data_rd_chk();
    logic [7:0] d, e;
    e = (rx_q.size() != 0) ? rx_q[0] : 8'h00;
    host_rd(4'd0, d);
    chk("R5 data read", d, e);
    if (rx_q.size() != 0) void'(rx_q.pop_front());
  endtask

  task automatic drain_one();
    @(negedge clk);
    h2c_ready = 1;
    #1;
    chk("R1 h2c_valid", {7'd0, h2c_valid}, {7'd0, tx_q.size() != 0});
    if (tx_q.size() != 0) begin
      chk("R1 order", h2c_data, tx_q[0]);
      void'(tx_q.pop_front());
    end
    @(posedge clk); #1;
    h2c_ready = 0;
  endtask

  task automatic push_rx(logic [7:0] d);
    @(negedge clk);
    c2h_valid = 1; c2h_data = d;
    #1;
    chk("R12 c2h_ready", {7'd0, c2h_ready}, {7'd0, rx_q.size() < RXD});
    if (rx_q.size() < RXD) rx_q.push_back(d);
    @(posedge clk); #1;
    c2h_valid = 0;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    irq_event = 1;
    @(posedge clk); #1;
    irq_event = 0;
    pend_m = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 reset state
    chk("R10 h2c_valid", {7'd0, h2c_valid}, 8'd0);
    chk("R10 c2h_ready", {7'd0, c2h_ready}, 8'd1);
    status_chk("R10 status");

    // R3 threshold edge
    for (int i = 0; i < TXD/2; i++) host_wr(4'd0, 8'(i + 8'h10));
    status_chk("R3 at half");
    host_wr(4'd0, 8'h55);
    status_chk("R3 above half");
    // R2 fill and overflow discard
    while (tx_q.size() < TXD) host_wr(4'd0, 8'($urandom));
    status_chk("R2 full");
    host_wr(4'd0, 8'hEE);
    status_chk("R2 still full");
    for (int i = 0; i < TXD; i++) drain_one();
    drain_one();
    status_chk("R1 drained");

    // R5 empty read, R4 fill, R12 back-pressure
    data_rd_chk();
    status_chk("R4 rx empty");
    for (int i = 0; i < RXD + 1; i++) push_rx(8'(8'hA0 + i));
    status_chk("R4 rx not empty");
    for (int i = 0; i < RXD + 1; i++) data_rd_chk();

    // R6 R7 R8 R9 control register
    host_wr(4'd4, 8'h40);
    status_chk("R6 enable");
    pulse_evt();
    status_chk("R7 pending set");
    host_wr(4'd4, 8'h40);
    status_chk("R7 write 0 keeps pending");
    host_wr(4'd4, 8'h9F);
    status_chk("R9 read-only bits");
    pulse_evt();
    @(negedge clk);
    irq_event = 1; host_cs = 1; host_we = 1; host_addr = 4'd4; host_wdata = 8'h60;
    @(posedge clk); #1;
    irq_event = 0; host_cs = 0; host_we = 0;
    en_m = 1; pend_m = 1;
    status_chk("R7 event beats clear");

    // R11 other offsets
    host_wr(4'd8, 8'h33);
    host_rd(4'd8, d);
    chk("R11 other offset", d, 8'h00);
    status_chk("R11 no side effect");

    // random phase
    for (int n = 0; n < 600; n++) begin
      case ($urandom % 7)
        0, 1: host_wr(4'd0, 8'($urandom));
        2: data_rd_chk();
        3: drain_one();
        4: push_rx(8'($urandom));
        5: if ($urandom % 4 == 0) pulse_evt(); else host_wr(4'd4, 8'($urandom));
        default: status_chk("R2 R3 R4 random status");
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule